// File: doc/BRIEF.md
# Multiple-Sector Block Transfer Sequencer

This block paces a programmed-I/O transfer of many sectors between a host and a sector buffer, grouping the sectors into blocks so that the host is interrupted once per block instead of once per sector. A separate configuration request first fixes the block size in sectors. A start request then loads the number of sectors wanted, and the block alternates between waiting for the buffer (busy) and offering one block of data to the host (data request). The host moves the block as 16-bit words, 256 words to a sector. The last block is cut short to whatever sectors remain.

The remaining-sector count is always visible. When the transfer ends normally it reads zero. When an error stops it, the count gives the sectors that were not fully transferred. A software reset drops any transfer in progress but keeps the configured block size. Reads and writes differ only in where the interrupts fall. A read interrupts when each block becomes available. A write interrupts when each later block is requested and once more at the end.

Top module: `multiblk_seq`

## Requirements
- R1: A configuration request (cfgValid) with a count of 1 to MAX_BLOCK (16) stores that count as the block size, pulses intrqPulse and leaves abortFlag low.
- R2: A configuration request with a count of 0 or above MAX_BLOCK sets abortFlag, pulses intrqPulse, and leaves any earlier block size in force.
- R3: A start request (startValid) made before any block size was accepted is refused: abortFlag is set, intrqPulse pulses and bsy stays low.
- R4: A start count of 0 means 256 sectors; the remaining count shows 256 from the cycle after the start.
- R5: Each block holds min(remaining, block size) sectors, and drq stays high until exactly that many times 256 word strobes have arrived.
- R6: For a read (isWrite=0), intrqPulse fires in the first cycle that drq is high for every block, and remCount at that moment is the count before the block.
- R7: For a write (isWrite=1), the first block raises drq with no interrupt, every later block interrupts as in R6, and one more interrupt, with drq low and remCount 0, follows the last word.
- R8: remCount drops by one after every 256th word strobe and reads 0 once the transfer is complete; it does not change while drq is high without a strobe.
- R9: errIn during a transfer stops it in the next cycle: bsy and drq go low, errFlag is set, intrqPulse pulses, and remCount holds the sectors not fully transferred.
- R10: bsy is high while the block waits for bufReady and low while drq is high; word strobes when drq is low, and bufReady or errIn when idle, have no effect.
- R11: softRst ends any transfer (bsy and drq low) but keeps the block size for later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset; clears the block size as well |
| softRst | input | 1 | Software reset; abandons the transfer and keeps the block size |
| cfgValid | input | 1 | One-cycle block-size configuration request |
| cfgCount | input | 8 | Requested sectors per block |
| startValid | input | 1 | One-cycle start of a multiple-sector transfer |
| startCount | input | 8 | Requested sectors, 0 meaning 256 |
| isWrite | input | 1 | Direction of the transfer started with startValid |
| bufReady | input | 1 | Buffer holds or can take the next block |
| wordStrobe | input | 1 | One 16-bit word moved by the host |
| errIn | input | 1 | Error raised during the transfer |
| drq | output | 1 | Data request; host may move words |
| bsy | output | 1 | Busy waiting on the buffer |
| intrqPulse | output | 1 | One-cycle interrupt |
| remCount | output | 9 | Sectors not yet transferred |
| errFlag | output | 1 | Last transfer ended in error |
| abortFlag | output | 1 | Last request was refused |

## Verification
The hardest case to reach is an error that lands partway through a sector of a later block. It shows whether the remaining count leaves out the partial sector and includes every sector already finished. The driver counts every word it strobes and raises errIn at a chosen word index in the second block. The model then works out the expected count from whole sectors alone. The 256-sector request with 16-sector blocks is run in full, so the count wraps through its top value. Word strobes sent while the block waits for the buffer test that they are ignored.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } msqState_t;

  typedef struct packed {
    logic loadCfg;
    logic loadRem;
    logic loadBlk;
    logic countWord;
  } msqStrobes_t;
endpackage

// File: rtl/msq_datapath.sv
module msq_datapath
  import msq_pkg::*;
#(
  parameter int WORDS_PER_SECTOR = 256,
  parameter int MAX_BLOCK        = 16,
  parameter int CNT_W            = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  msqStrobes_t                           strb,
  input  logic [CNT_W-1:0]                      cfgCount,
  input  logic [CNT_W-1:0]                      startCount,
  output logic                                  cfgOk,
  output logic                                  blkSet,
  output logic                                  secEnd,
  output logic                                  blkEnd,
  output logic                                  lastSector,
  output logic                                  firstBlk,
  output logic [$clog2((2**CNT_W)+1)-1:0]       remCount
);
  localparam int MAX_SECTORS = 2 ** CNT_W;
  localparam int REM_W       = $clog2(MAX_SECTORS + 1);
  localparam int BLK_W       = $clog2(MAX_BLOCK + 1);
  localparam int WORD_W      = (WORDS_PER_SECTOR > 1) ? $clog2(WORDS_PER_SECTOR) : 1;

  logic [BLK_W-1:0]  blkSizeQ;
  logic              blkSetQ;
  logic [REM_W-1:0]  remQ;
  logic [WORD_W-1:0] wordQ;
  logic [BLK_W-1:0]  secLeftQ;
  logic              firstQ;

  logic [REM_W-1:0]  blkSizeExt;
  logic [BLK_W-1:0]  nextBlk;
  logic              wordWrap;

  assign blkSizeExt = REM_W'(blkSizeQ);
  assign nextBlk    = (remQ < blkSizeExt) ? BLK_W'(remQ) : blkSizeQ;
  assign wordWrap   = (wordQ == WORD_W'(WORDS_PER_SECTOR - 1));

  assign cfgOk      = (cfgCount != '0) && (cfgCount <= CNT_W'(MAX_BLOCK));
  assign secEnd     = strb.countWord && wordWrap;
  assign blkEnd     = secEnd && (secLeftQ == BLK_W'(1));
  assign lastSector = (remQ == REM_W'(1));
  assign blkSet     = blkSetQ;
  assign firstBlk   = firstQ;
  assign remCount   = remQ;

  // block size survives everything except the hard reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkSizeQ <= '0;
      blkSetQ  <= 1'b0;
    end else if (strb.loadCfg) begin
      blkSizeQ <= BLK_W'(cfgCount);
      blkSetQ  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ   <= '0;
      firstQ <= 1'b0;
    end else if (strb.loadRem) begin
      remQ   <= (startCount == '0) ? REM_W'(MAX_SECTORS) : REM_W'(startCount);
      firstQ <= 1'b1;
    end else if (secEnd) begin
      remQ <= remQ - REM_W'(1);
      if (blkEnd) firstQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ    <= '0;
      secLeftQ <= '0;
    end else if (strb.loadBlk) begin
      wordQ    <= '0;
      secLeftQ <= nextBlk;
    end else if (strb.countWord) begin
      wordQ <= wordWrap ? '0 : wordQ + WORD_W'(1);
      if (wordWrap) secLeftQ <= secLeftQ - BLK_W'(1);
    end
  end
endmodule

// File: rtl/msq_control.sv
module msq_control
  import msq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic        cfgValid,
  input  logic        cfgOk,
  input  logic        startValid,
  input  logic        isWrite,
  input  logic        blkSet,
  input  logic        bufReady,
  input  logic        wordStrobe,
  input  logic        errIn,
  input  logic        blkEnd,
  input  logic        lastSector,
  input  logic        firstBlk,
  output msqStrobes_t strb,
  output logic        drq,
  output logic        bsy,
  output logic        intrqPulse,
  output logic        errFlag,
  output logic        abortFlag
);
  msqState_t stateQ, stateD;
  logic dirWriteQ, dirWriteD;
  logic intrqQ, intrqD;
  logic errQ, errD;
  logic abortQ, abortD;

  always_comb begin
    stateD    = stateQ;
    dirWriteD = dirWriteQ;
    intrqD    = 1'b0;
    errD      = errQ;
    abortD    = abortQ;
    strb      = '0;
    if (softRst) begin
      stateD = ST_IDLE;
      errD   = 1'b0;
      abortD = 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (cfgValid) begin
            intrqD       = 1'b1;
            errD         = 1'b0;
            abortD       = !cfgOk;
            strb.loadCfg = cfgOk;
          end else if (startValid) begin
            errD = 1'b0;
            if (blkSet) begin
              abortD       = 1'b0;
              strb.loadRem = 1'b1;
              dirWriteD    = isWrite;
              stateD       = ST_WAIT;
            end else begin
              abortD = 1'b1;
              intrqD = 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (errIn) begin
            stateD = ST_IDLE;
            errD   = 1'b1;
            intrqD = 1'b1;
          end else if (bufReady) begin
            strb.loadBlk = 1'b1;
            stateD       = ST_XFER;
            intrqD       = !dirWriteQ || !firstBlk;
          end
        end
        ST_XFER: begin
          if (errIn) begin
            stateD = ST_IDLE;
            errD   = 1'b1;
            intrqD = 1'b1;
          end else if (wordStrobe) begin
            strb.countWord = 1'b1;
            if (blkEnd) begin
              if (lastSector) begin
                stateD = ST_IDLE;
                intrqD = dirWriteQ;
              end else begin
                stateD = ST_WAIT;
              end
            end
          end
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      dirWriteQ <= 1'b0;
      intrqQ    <= 1'b0;
      errQ      <= 1'b0;
      abortQ    <= 1'b0;
    end else begin
      stateQ    <= stateD;
      dirWriteQ <= dirWriteD;
      intrqQ    <= intrqD;
      errQ      <= errD;
      abortQ    <= abortD;
    end
  end

  assign drq        = (stateQ == ST_XFER);
  assign bsy        = (stateQ == ST_WAIT);
  assign intrqPulse = intrqQ;
  assign errFlag    = errQ;
  assign abortFlag  = abortQ;
endmodule

// File: rtl/multiblk_seq.sv
module multiblk_seq
  import msq_pkg::*;
#(
  parameter int WORDS_PER_SECTOR = 256,
  parameter int MAX_BLOCK        = 16,
  parameter int CNT_W            = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            softRst,
  input  logic                            cfgValid,
  input  logic [CNT_W-1:0]                cfgCount,
  input  logic                            startValid,
  input  logic [CNT_W-1:0]                startCount,
  input  logic                            isWrite,
  input  logic                            bufReady,
  input  logic                            wordStrobe,
  input  logic                            errIn,
  output logic                            drq,
  output logic                            bsy,
  output logic                            intrqPulse,
  output logic [$clog2((2**CNT_W)+1)-1:0] remCount,
  output logic                            errFlag,
  output logic                            abortFlag
);
  msqStrobes_t strb;
  logic cfgOk, blkSet, secEnd, blkEnd, lastSector, firstBlk;

  msq_control u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .cfgValid(cfgValid), .cfgOk(cfgOk),
    .startValid(startValid), .isWrite(isWrite), .blkSet(blkSet),
    .bufReady(bufReady), .wordStrobe(wordStrobe), .errIn(errIn),
    .blkEnd(blkEnd), .lastSector(lastSector), .firstBlk(firstBlk),
    .strb(strb), .drq(drq), .bsy(bsy), .intrqPulse(intrqPulse),
    .errFlag(errFlag), .abortFlag(abortFlag)
  );

  msq_datapath #(
    .WORDS_PER_SECTOR(WORDS_PER_SECTOR), .MAX_BLOCK(MAX_BLOCK), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgCount(cfgCount), .startCount(startCount),
    .cfgOk(cfgOk), .blkSet(blkSet), .secEnd(secEnd), .blkEnd(blkEnd),
    .lastSector(lastSector), .firstBlk(firstBlk), .remCount(remCount)
  );
endmodule

// File: rtl/multiblk_seq_chk.sv
module multiblk_seq_chk #(
  parameter int MAX_BLOCK = 16,
  parameter int CNT_W     = 8
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            softRst,
  input logic                            cfgValid,
  input logic [CNT_W-1:0]                cfgCount,
  input logic                            startValid,
  input logic [CNT_W-1:0]                startCount,
  input logic                            wordStrobe,
  input logic                            errIn,
  input logic                            drq,
  input logic                            bsy,
  input logic                            intrqPulse,
  input logic [$clog2((2**CNT_W)+1)-1:0] remCount,
  input logic                            errFlag,
  input logic                            abortFlag
);
  localparam int MAX_SECTORS = 2 ** CNT_W;

  assert_drq_bsy_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(drq && bsy));

  assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!bsy && !drq && !cfgValid && startValid && startCount == '0 && !softRst)
    |=> (!bsy || remCount == MAX_SECTORS));

  assert_rem_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (drq && !wordStrobe && !softRst) |=> (remCount == $past(remCount)));

  assert_drq_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (drq && !wordStrobe && !errIn && !softRst) |=> drq);

  assert_err_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((drq || bsy) && errIn && !softRst) |=> (!drq && !bsy && errFlag && intrqPulse));

  assert_bad_cfg_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!drq && !bsy && cfgValid && !softRst &&
     (cfgCount == '0 || cfgCount > CNT_W'(MAX_BLOCK)))
    |=> (abortFlag && intrqPulse));
endmodule

bind multiblk_seq multiblk_seq_chk #(.MAX_BLOCK(MAX_BLOCK), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .cfgValid(cfgValid),
  .cfgCount(cfgCount), .startValid(startValid), .startCount(startCount),
  .wordStrobe(wordStrobe), .errIn(errIn), .drq(drq), .bsy(bsy),
  .intrqPulse(intrqPulse), .remCount(remCount), .errFlag(errFlag),
  .abortFlag(abortFlag)
);

// File: tb/multiblk_seq_bench.sv
`timescale 1ns/1ps
module multiblk_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0, cfgValid = 1'b0, startValid = 1'b0, isWrite = 1'b0;
  logic bufReady = 1'b0, wordStrobe = 1'b0, errIn = 1'b0;
  logic [7:0] cfgCount = '0, startCount = '0;
  logic drq, bsy, intrqPulse, errFlag, abortFlag;
  logic [8:0] remCount;

  int checks = 0, failures = 0;
  int modelBs = 0, modelRem = 0;
  bit finished = 0;
  logic [11:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  multiblk_seq u_multiblk_seq (
    .clk(clk), .rstN(rstN), .softRst(softRst), .cfgValid(cfgValid),
    .cfgCount(cfgCount), .startValid(startValid), .startCount(startCount),
    .isWrite(isWrite), .bufReady(bufReady), .wordStrobe(wordStrobe),
    .errIn(errIn), .drq(drq), .bsy(bsy), .intrqPulse(intrqPulse),
    .remCount(remCount), .errFlag(errFlag), .abortFlag(abortFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input bit d, input bit e, input bit a, input int r);
    return {d, e, a, 9'(r)};
  endfunction

  task automatic expect_irq(input logic [11:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // monitor: every interrupt is compared with the next expected item
  always @(negedge clk) begin
    if (rstN && intrqPulse) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "unexpected interrupt", {20'd0, drq, errFlag, abortFlag, remCount}, 0);
      end else begin
        logic [11:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({drq, errFlag, abortFlag, remCount} == e, t,
            {20'd0, drq, errFlag, abortFlag, remCount}, {20'd0, e});
      end
    end
  end

  task automatic doCfg(input int v);
    bit ok;
    ok = (v >= 1 && v <= 16);
    expect_irq(mk(0, 0, !ok, modelRem), ok ? "R1 cfg irq" : "R2 cfg irq");
    if (ok) modelBs = v;
    @(negedge clk); cfgValid = 1'b1; cfgCount = 8'(v);
    @(negedge clk); cfgValid = 1'b0;
    chk(abortFlag == !ok, ok ? "R1 abort low" : "R2 abort set", abortFlag, !ok);
  endtask

  // full transfer; errAt = word index at which errIn is raised, -1 for none
  task automatic runXfer(input int count, input bit wr, input int errAt, input string tag);
    int n, rem, total, cur;
    bit first;
    n = (count == 0) ? 256 : count;
    rem = n; total = 0; first = 1;
    @(negedge clk); startValid = 1'b1; startCount = 8'(count); isWrite = wr;
    @(negedge clk); startValid = 1'b0;
    chk(bsy == 1'b1, "R10 busy after start", bsy, 1);
    chk(remCount == 9'(n), count == 0 ? "R4 zero means 256" : "R8 count loaded", remCount, n);
    // stray strobes while waiting on the buffer
    wordStrobe = 1'b1;
    repeat (3) @(negedge clk);
    wordStrobe = 1'b0;
    chk(remCount == 9'(n) && bsy, "R10 strobe ignored while busy", remCount, n);
    while (rem > 0) begin
      cur = (rem < modelBs) ? rem : modelBs;
      if (!wr || !first) expect_irq(mk(1, 0, 0, rem), wr ? "R7 write block irq" : "R6 read block irq");
      bufReady = 1'b1;
      @(negedge clk); bufReady = 1'b0;
      chk(drq == 1'b1 && bsy == 1'b0, "R10 drq with bsy low", {drq, bsy}, 2);
      for (int w = 0; w < cur * 256; w++) begin
        if (total == errAt) begin
          wordStrobe = 1'b0;
          expect_irq(mk(0, 1, 0, n - total / 256), "R9 error irq");
          errIn = 1'b1;
          @(negedge clk); errIn = 1'b0;
          chk(!bsy && !drq && errFlag, "R9 stopped", {bsy, drq, errFlag}, 1);
          chk(remCount == 9'(n - total / 256), "R9 remaining", remCount, n - total / 256);
          modelRem = n - total / 256;
          return;
        end
        if (wr && rem == cur && w == cur * 256 - 1) expect_irq(mk(0, 0, 0, 0), "R7 final irq");
        wordStrobe = 1'b1;
        @(negedge clk);
        total++;
        if (w == cur * 256 - 2) chk(drq == 1'b1, "R5 drq held", drq, 1);
      end
      wordStrobe = 1'b0;
      rem -= cur;
      first = 0;
      chk(drq == 1'b0, "R5 drq drops at block end", drq, 0);
      chk(remCount == 9'(rem), {tag, " R8 count after block"}, remCount, rem);
      if (rem > 0) chk(bsy == 1'b1, "R10 busy between blocks", bsy, 1);
    end
    chk(!bsy && !drq && !errFlag, "R8 completed idle", {bsy, drq, errFlag}, 0);
    modelRem = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!bsy && !drq && !intrqPulse && remCount == 0 && !errFlag && !abortFlag,
        "reset state", {bsy, drq, intrqPulse, errFlag, abortFlag}, 0);

    // R3: start before any size is set
    expect_irq(mk(0, 0, 1, 0), "R3 refused irq");
    @(negedge clk); startValid = 1'b1; startCount = 8'd5;
    @(negedge clk); startValid = 1'b0;
    chk(!bsy && abortFlag, "R3 start refused", {bsy, abortFlag}, 1);

    doCfg(0);
    doCfg(17);
    chk(!bsy, "R2 no transfer", bsy, 0);
    doCfg(4);
    doCfg(0);   // refused; size 4 must remain

    // R10: idle inputs ignored
    bufReady = 1'b1; wordStrobe = 1'b1; errIn = 1'b1;
    @(negedge clk); @(negedge clk);
    bufReady = 1'b0; wordStrobe = 1'b0; errIn = 1'b0;
    chk(!bsy && !drq && !errFlag && remCount == 0, "R10 idle ignore", {bsy, drq, errFlag}, 0);

    runXfer(9, 0, -1, "R6 read 9/4");
    runXfer(9, 1, -1, "R7 write 9/4");
    runXfer(9, 0, 1324, "R9 error in block 2");

    doCfg(1);
    runXfer(2, 0, -1, "R5 single-sector blocks");

    // R11: software reset mid-transfer keeps block size
    doCfg(2);
    @(negedge clk); startValid = 1'b1; startCount = 8'd6; isWrite = 1'b0;
    @(negedge clk); startValid = 1'b0;
    expect_irq(mk(1, 0, 0, 6), "R11 block irq before reset");
    bufReady = 1'b1; @(negedge clk); bufReady = 1'b0;
    wordStrobe = 1'b1; repeat (10) @(negedge clk); wordStrobe = 1'b0;
    softRst = 1'b1; @(negedge clk); softRst = 1'b0;
    chk(!bsy && !drq, "R11 soft reset idle", {bsy, drq}, 0);
    modelRem = 6;
    runXfer(3, 0, -1, "R11 size kept");

    doCfg(16);
    runXfer(0, 0, -1, "R4 256 sectors");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R6 all interrupts seen", expQ.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule